// File: doc/BRIEF.md
# Rename Map and Register File

This block keeps, for every architectural register of a Tomasulo-style core, either the value committed in a small register file or the tag of the station that will produce the register's next value. It has two combinational lookup ports and one issue write. An instruction being issued presents two source register indices. For each source the block returns one of two things: a value that is ready now, or the tag of the pending producer that a reservation station must wait for. On the same clock edge the block records the issuing station's tag against the destination register.

A result broadcast carries a destination register, a producer tag and a value. The broadcast counts only when the alias entry for that register still names the broadcasting tag. In that case the value goes into the register file and the alias entry returns to empty. An empty entry means the register file holds the current value. A broadcast from a producer that has since been superseded changes nothing. A source lookup made during the cycle of a live broadcast to that register returns the broadcast value directly.

Top module: `regmap_unit`

## Requirements
- R1: A source register whose alias entry is occupied is reported with `*_pending`=1 and the entry's tag on `*_tag`.
- R2: A source register whose alias entry is empty is reported with `*_pending`=0 and the register file contents on `*_value`.
- R3: With `iss_valid`=1, after the clock edge the alias entry of `iss_dst` holds `iss_tag` and is occupied.
- R4: A broadcast whose tag equals the occupied alias entry of `bc_dst` writes `bc_value` to the register file and empties that entry.
- R5: A broadcast whose tag does not match the alias entry of `bc_dst` (or finds it empty) leaves the alias table unchanged.
- R6: Issues take effect in the order presented: a later issue to the same register replaces the earlier tag, and the earlier producer becomes stale.
- R7: A stale broadcast does not write the register file.
- R8: When an issue and a live broadcast name the same register in one cycle, the entry afterwards holds the new issue tag and stays occupied.
- R9: After reset every alias entry is empty and every register file entry reads zero.
- R10: If a live broadcast targets a source register in the lookup cycle, that source is reported ready with `bc_value`. A stale broadcast causes no such forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Records a new mapping for `iss_dst` on this edge |
| iss_src_a | input | IDX_W | First source register index |
| iss_src_b | input | IDX_W | Second source register index |
| iss_dst | input | IDX_W | Destination register of the issuing instruction |
| iss_tag | input | TAG_W | Tag of the issuing station |
| bc_valid | input | 1 | Result broadcast present |
| bc_dst | input | IDX_W | Destination register of the broadcast result |
| bc_tag | input | TAG_W | Producer tag of the broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| a_pending | output | 1 | 1: first source waits on `a_tag`; 0: `a_value` is ready |
| a_tag | output | TAG_W | Producer tag for the first source |
| a_value | output | DATA_W | Ready value for the first source |
| b_pending | output | 1 | 1: second source waits on `b_tag`; 0: `b_value` is ready |
| b_tag | output | TAG_W | Producer tag for the second source |
| b_value | output | DATA_W | Ready value for the second source |

## Verification
Lookups are tried against empty, occupied, and just-cleared entries, which separates values read from the file from tags read from the table. Broadcasts are sent with a matching tag, with an outdated tag to a remapped register, and with any tag to an already empty register. These three cases distinguish a live result from the two kinds of stale result. Further cases cover an issue and a broadcast to the same register in one cycle, and lookups made during the broadcast cycle. They show whether the new mapping wins over the clear and whether forwarding happens only for live results.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

   // Kind of operand handed back by a source lookup
   typedef enum logic {
      SRC_READY   = 1'b0,
      SRC_WAITING = 1'b1
   } src_kind_e;

endpackage

// File: rtl/regmap_alias.sv
module regmap_alias #(
   parameter int NUM_REGS = 8,
   parameter int TAG_W    = 3,
   parameter int IDX_W    = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           iss_we,
   input  logic [IDX_W-1:0]               iss_dst,
   input  logic [TAG_W-1:0]               iss_tag,
   input  logic                           bc_valid,
   input  logic [IDX_W-1:0]               bc_dst,
   input  logic [TAG_W-1:0]               bc_tag,
   output logic                           bc_live,
   output logic [NUM_REGS-1:0]            map_vld,
   output logic [NUM_REGS-1:0][TAG_W-1:0] map_tag
);

   logic [NUM_REGS-1:0]            vld_q;
   logic [NUM_REGS-1:0][TAG_W-1:0] tag_q;

   // A broadcast is live only while the entry still names its producer
   always_comb begin
      bc_live = bc_valid && vld_q[bc_dst] && (tag_q[bc_dst] == bc_tag);
   end

   // The issue write comes last so that it overrides a clear to the same entry
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         tag_q <= '0;
      end else begin
         if (bc_live) begin
            vld_q[bc_dst] <= 1'b0;
         end
         if (iss_we) begin
            vld_q[iss_dst] <= 1'b1;
            tag_q[iss_dst] <= iss_tag;
         end
      end
   end

   assign map_vld = vld_q;
   assign map_tag = tag_q;

endmodule

// File: rtl/regmap_datafile.sv
module regmap_datafile #(
   parameter int NUM_REGS = 8,
   parameter int DATA_W   = 16,
   parameter int IDX_W    = 3,
   parameter int NUM_RD   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [NUM_RD-1:0][IDX_W-1:0] rd_idx,
   output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

   logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (wr_en) begin
         mem_q[wr_idx] <= wr_data;
      end
   end

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rd_data[p] = mem_q[rd_idx[p]];
   end

endmodule

// File: rtl/regmap_srcsel.sv
module regmap_srcsel
   import regmap_pkg::*;
#(
   parameter int  TAG_W     = 3,
   parameter int  DATA_W    = 16,
   parameter bit  FORWARD   = 1'b1
) (
   input  logic              entry_vld,
   input  logic [TAG_W-1:0]  entry_tag,
   input  logic [DATA_W-1:0] file_value,
   input  logic              fwd_hit,
   input  logic [DATA_W-1:0] fwd_value,
   output src_kind_e         kind,
   output logic [TAG_W-1:0]  tag,
   output logic [DATA_W-1:0] value
);

   assign tag = entry_tag;

   if (FORWARD) begin : g_fwd
      always_comb begin
         if (fwd_hit) begin
            kind  = SRC_READY;
            value = fwd_value;
         end else begin
            kind  = entry_vld ? SRC_WAITING : SRC_READY;
            value = file_value;
         end
      end
   end else begin : g_nofwd
      logic unused_fwd;
      assign unused_fwd = fwd_hit ^ (^fwd_value);
      always_comb begin
         kind  = entry_vld ? SRC_WAITING : SRC_READY;
         value = file_value;
      end
   end

endmodule

// File: rtl/regmap_unit.sv
module regmap_unit
   import regmap_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int TAG_W    = 3,
   parameter int DATA_W   = 16,
   parameter bit FORWARD  = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [IDX_W-1:0]  iss_src_a,
   input  logic [IDX_W-1:0]  iss_src_b,
   input  logic [IDX_W-1:0]  iss_dst,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              bc_valid,
   input  logic [IDX_W-1:0]  bc_dst,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_value,
   output logic              a_pending,
   output logic [TAG_W-1:0]  a_tag,
   output logic [DATA_W-1:0] a_value,
   output logic              b_pending,
   output logic [TAG_W-1:0]  b_tag,
   output logic [DATA_W-1:0] b_value
);

   localparam int NUM_SRC = 2;

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("TAG_W and DATA_W must be positive");
   end

   logic                           bc_live;
   logic [NUM_REGS-1:0]            map_vld;
   logic [NUM_REGS-1:0][TAG_W-1:0] map_tag;
   logic [NUM_SRC-1:0][IDX_W-1:0]  src_idx;
   logic [NUM_SRC-1:0][DATA_W-1:0] src_file;
   src_kind_e [NUM_SRC-1:0]        src_kind;
   logic [NUM_SRC-1:0][TAG_W-1:0]  src_tag;
   logic [NUM_SRC-1:0][DATA_W-1:0] src_val;

   assign src_idx[0] = iss_src_a;
   assign src_idx[1] = iss_src_b;

   regmap_alias #(
      .NUM_REGS (NUM_REGS),
      .TAG_W    (TAG_W),
      .IDX_W    (IDX_W)
   ) u_alias (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_we   (iss_valid),
      .iss_dst  (iss_dst),
      .iss_tag  (iss_tag),
      .bc_valid (bc_valid),
      .bc_dst   (bc_dst),
      .bc_tag   (bc_tag),
      .bc_live  (bc_live),
      .map_vld  (map_vld),
      .map_tag  (map_tag)
   );

   regmap_datafile #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .NUM_RD   (NUM_SRC)
   ) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bc_live),
      .wr_idx   (bc_dst),
      .wr_data  (bc_value),
      .rd_idx   (src_idx),
      .rd_data  (src_file)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      regmap_srcsel #(
         .TAG_W   (TAG_W),
         .DATA_W  (DATA_W),
         .FORWARD (FORWARD)
      ) u_sel (
         .entry_vld  (map_vld[src_idx[s]]),
         .entry_tag  (map_tag[src_idx[s]]),
         .file_value (src_file[s]),
         .fwd_hit    (bc_live && (bc_dst == src_idx[s])),
         .fwd_value  (bc_value),
         .kind       (src_kind[s]),
         .tag        (src_tag[s]),
         .value      (src_val[s])
      );
   end

   assign a_pending = (src_kind[0] == SRC_WAITING);
   assign a_tag     = src_tag[0];
   assign a_value   = src_val[0];
   assign b_pending = (src_kind[1] == SRC_WAITING);
   assign b_tag     = src_tag[1];
   assign b_value   = src_val[1];

endmodule

// File: rtl/regmap_unit_chk.sv
module regmap_unit_chk #(
   parameter int NUM_REGS = 8,
   parameter int TAG_W    = 3,
   parameter int IDX_W    = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           iss_valid,
   input logic [IDX_W-1:0]               iss_src_a,
   input logic [IDX_W-1:0]               iss_dst,
   input logic [TAG_W-1:0]               iss_tag,
   input logic                           bc_valid,
   input logic [IDX_W-1:0]               bc_dst,
   input logic [TAG_W-1:0]               bc_tag,
   input logic                           a_pending,
   input logic [TAG_W-1:0]               a_tag,
   input logic [NUM_REGS-1:0]            map_vld,
   input logic [NUM_REGS-1:0][TAG_W-1:0] map_tag
);

   logic matched;
   logic same_dst;
   assign matched  = bc_valid && map_vld[bc_dst] && (map_tag[bc_dst] == bc_tag);
   assign same_dst = iss_valid && (iss_dst == bc_dst);

   // R3
   issue_records_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> map_vld[$past(iss_dst)] && (map_tag[$past(iss_dst)] == $past(iss_tag)));

   // R4
   live_clears_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (matched && !same_dst) |=> !map_vld[$past(bc_dst)]);

   // R5
   stale_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && !matched && !same_dst) |=>
         (map_vld[$past(bc_dst)] == $past(map_vld[bc_dst])) &&
         (map_tag[$past(bc_dst)] == $past(map_tag[bc_dst])));

   // R1
   waiting_source_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (map_vld[iss_src_a] && !(bc_valid && bc_dst == iss_src_a)) |->
         (a_pending && a_tag == map_tag[iss_src_a]));

   // R9
   reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (map_vld == '0));

endmodule

bind regmap_unit regmap_unit_chk #(
   .NUM_REGS (NUM_REGS),
   .TAG_W    (TAG_W),
   .IDX_W    (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_valid (iss_valid),
   .iss_src_a (iss_src_a),
   .iss_dst   (iss_dst),
   .iss_tag   (iss_tag),
   .bc_valid  (bc_valid),
   .bc_dst    (bc_dst),
   .bc_tag    (bc_tag),
   .a_pending (a_pending),
   .a_tag     (a_tag),
   .map_vld   (map_vld),
   .map_tag   (map_tag)
);

// File: tb/regmap_unit_tb.sv
module regmap_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NREG = 8;
   localparam int IW   = 3;
   localparam int TW   = 3;
   localparam int DW   = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          iss_valid;
   logic [IW-1:0] iss_src_a, iss_src_b, iss_dst;
   logic [TW-1:0] iss_tag;
   logic          bc_valid;
   logic [IW-1:0] bc_dst;
   logic [TW-1:0] bc_tag;
   logic [DW-1:0] bc_value;
   logic          a_pending, b_pending;
   logic [TW-1:0] a_tag, b_tag;
   logic [DW-1:0] a_value, b_value;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regmap_unit #(.NUM_REGS(NREG), .TAG_W(TW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
      .iss_dst(iss_dst), .iss_tag(iss_tag),
      .bc_valid(bc_valid), .bc_dst(bc_dst), .bc_tag(bc_tag), .bc_value(bc_value),
      .a_pending(a_pending), .a_tag(a_tag), .a_value(a_value),
      .b_pending(b_pending), .b_tag(b_tag), .b_value(b_value)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic idle();
      iss_valid = 1'b0; iss_dst = '0; iss_tag = '0;
      bc_valid = 1'b0; bc_dst = '0; bc_tag = '0; bc_value = '0;
   endtask

   // Clock edge, then settle just after the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle();
      #1;
   endtask

   task automatic look_a(input logic [IW-1:0] r, input string req,
                         input logic pend, input logic [TW-1:0] tg, input logic [DW-1:0] val);
      iss_src_a = r;
      #1;
      chk({req, " a_pending"}, 32'(a_pending), 32'(pend));
      if (pend) chk({req, " a_tag"}, 32'(a_tag), 32'(tg));
      else      chk({req, " a_value"}, 32'(a_value), 32'(val));
   endtask

   task automatic look_b(input logic [IW-1:0] r, input string req,
                         input logic pend, input logic [TW-1:0] tg, input logic [DW-1:0] val);
      iss_src_b = r;
      #1;
      chk({req, " b_pending"}, 32'(b_pending), 32'(pend));
      if (pend) chk({req, " b_tag"}, 32'(b_tag), 32'(tg));
      else      chk({req, " b_value"}, 32'(b_value), 32'(val));
   endtask

   task automatic t_reset();
      for (int r = 0; r < NREG; r++) begin
         look_a(IW'(r), "R9", 1'b0, '0, '0);
         look_b(IW'(r), "R9", 1'b0, '0, '0);
      end
   endtask

   task automatic t_issue();
      // R2: lookup of own destination before the edge sees the empty entry
      iss_valid = 1'b1; iss_dst = 3'd3; iss_tag = 3'd5;
      look_a(3'd3, "R2", 1'b0, '0, '0);
      step();
      look_a(3'd3, "R1", 1'b1, 3'd5, '0);
      look_b(3'd3, "R3", 1'b1, 3'd5, '0);
   endtask

   task automatic t_live();
      bc_valid = 1'b1; bc_dst = 3'd3; bc_tag = 3'd5; bc_value = 16'h1234;
      iss_src_a = 3'd0;
      step();
      look_a(3'd3, "R4", 1'b0, '0, 16'h1234);
   endtask

   task automatic t_stale_empty();
      bc_valid = 1'b1; bc_dst = 3'd3; bc_tag = 3'd5; bc_value = 16'h9999;
      look_b(3'd3, "R10", 1'b0, '0, 16'h1234);
      step();
      look_a(3'd3, "R7", 1'b0, '0, 16'h1234);
      look_b(3'd3, "R5", 1'b0, '0, 16'h1234);
   endtask

   task automatic t_stale_remap();
      iss_valid = 1'b1; iss_dst = 3'd2; iss_tag = 3'd1;
      step();
      iss_valid = 1'b1; iss_dst = 3'd2; iss_tag = 3'd4;
      step();
      look_a(3'd2, "R6", 1'b1, 3'd4, '0);
      bc_valid = 1'b1; bc_dst = 3'd2; bc_tag = 3'd1; bc_value = 16'hAAAA;
      look_b(3'd2, "R10", 1'b1, 3'd4, '0);
      step();
      look_a(3'd2, "R5", 1'b1, 3'd4, '0);
      bc_valid = 1'b1; bc_dst = 3'd2; bc_tag = 3'd4; bc_value = 16'hBBBB;
      step();
      look_a(3'd2, "R4", 1'b0, '0, 16'hBBBB);
   endtask

   task automatic t_same_cycle();
      iss_valid = 1'b1; iss_dst = 3'd6; iss_tag = 3'd2;
      step();
      iss_valid = 1'b1; iss_dst = 3'd6; iss_tag = 3'd7;
      bc_valid = 1'b1; bc_dst = 3'd6; bc_tag = 3'd2; bc_value = 16'h0055;
      step();
      look_a(3'd6, "R8", 1'b1, 3'd7, '0);
      bc_valid = 1'b1; bc_dst = 3'd6; bc_tag = 3'd7; bc_value = 16'h0077;
      step();
      look_a(3'd6, "R8", 1'b0, '0, 16'h0077);
   endtask

   task automatic t_forward();
      iss_valid = 1'b1; iss_dst = 3'd1; iss_tag = 3'd3;
      step();
      bc_valid = 1'b1; bc_dst = 3'd1; bc_tag = 3'd3; bc_value = 16'h4242;
      look_a(3'd1, "R10", 1'b0, '0, 16'h4242);
      look_b(3'd1, "R10", 1'b0, '0, 16'h4242);
      step();
      look_a(3'd1, "R4", 1'b0, '0, 16'h4242);
   endtask

   initial begin
      rst_n = 1'b0;
      iss_src_a = '0; iss_src_b = '0;
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_issue();
      t_live();
      t_stale_empty();
      t_stale_remap();
      t_same_cycle();
      t_forward();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule